// File: doc/BRIEF.md
# Grouped Interrupt Event Combiner

The combiner gathers 128 peripheral event lines into four groups of 32 and keeps a sticky pending flag for each event. Event number `e` lives in group `e / 32` at bit `e % 32`. A rising edge on an event line sets its flag. Software can also set flags, either by bit through a per-group set register or by event number through a raise register. It clears flags with write-one-to-clear. Each group drives one combined interrupt line. That line is high while any pending flag in the group has its mask bit at 0.

A second mask per group feeds an independent exception path. One exception output is high while any flag passes its exception mask in any group. Event numbers 0 to 3 are reserved as the identities of the four combined group outputs, so the input lines with those numbers are not sampled. The usual service routine reads a group's masked view, services the lowest set bit, clears it, and repeats until the view reads zero.

The register port is a single-cycle interface with byte addresses. Each region holds eight 32-bit words, and word `g` (byte offset `4*g`) belongs to group `g`. Region bases: pending flags 0x000, group mask 0x040, masked flags 0x060, exception mask 0x080, masked exception flags 0x0A0, set 0x100, clear 0x120, raise 0x140.

Top module: `evt_combiner`

## Requirements
- R1: After reset, every pending flag is 0, every group-mask bit and exception-mask bit is 1, and `grp_irq` and `exc_irq` are 0.
- R2: A rising edge on `evt_in[e]` with e >= 4 sets flag bit e%32 of group e/32 at the next clock edge. The flag stays set after the input drops. An input held high does not set the flag again once it has been cleared.
- R3: Input lines `evt_in[3:0]` (the reserved event numbers 0 to 3) have no effect on any flag.
- R4: Writing the set word at 0x100+4g sets every flag of group g whose data bit is 1. Data bits of 0 change nothing.
- R5: Writing the clear word at 0x120+4g clears every flag of group g whose data bit is 1. Data bits of 0 leave the flag unchanged. When a hardware edge sets a flag in the same cycle that it is cleared, the flag ends up set.
- R6: Writing the raise word at 0x140 with event number n in `wr_data[6:0]` sets flag bit n%32 of group n/32.
- R7: `grp_irq[g]` is high exactly when (pending & ~mask) of group g is nonzero. A mask bit of 1 blocks the event. The mask is read and written at 0x040+4g, and the read-only masked view is at 0x060+4g.
- R8: `exc_irq` is high exactly when (pending & ~exception mask) is nonzero in some group. This does not depend on the group masks. The exception mask is at 0x080+4g and its read-only masked view is at 0x0A0+4g.
- R9: A read with `rd_en` returns `rd_data` with `rd_valid` high one clock edge later, and `rd_valid` is 0 otherwise. The pending flags read at 0x000+4g. Words 4 to 7 of every region, and every word of the set, clear and raise regions, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 128 | Peripheral event lines, bit e is event e |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 9 | Byte address of the register word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |
| grp_irq | output | 4 | Combined interrupt of each group |
| exc_irq | output | 1 | Combined exception output |

## Verification
Flags and masks change at the first clock edge after the write strobe or input edge, and `grp_irq` and `exc_irq` follow from those registers with no further delay. The bench therefore checks the outputs at the falling edge that follows the stimulus edge. Read results come one edge after `rd_en`. The driver pushes each expected word into a queue at the moment it raises `rd_en`, and the monitor pops and compares that word at the next falling edge where `rd_valid` is high. The expected words come from a register model in the bench that is updated by the same tasks that drive the block.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Region selector taken from address bits [8:5]; each region holds 8 words
  typedef enum logic [3:0] {
    RG_PEND  = 4'h0,
    RG_MASK  = 4'h2,
    RG_MFLAG = 4'h3,
    RG_XMASK = 4'h4,
    RG_XFLAG = 4'h5,
    RG_SET   = 4'h8,
    RG_CLR   = 4'h9,
    RG_RAISE = 4'hA
  } region_e;

  localparam int unsigned ADDR_W = 9;
  localparam int unsigned WSEL_W = 3;

  function automatic logic [3:0] region_of(input logic [ADDR_W-1:0] a);
    return a[8:5];
  endfunction

  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[4:2];
  endfunction

endpackage

// File: rtl/evc_edge.sv
module evc_edge #(
  parameter int unsigned N    = 128,
  parameter int unsigned NRSV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_lines,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= in_lines;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < NRSV) begin : g_rsv
      assign rise[i] = 1'b0;
    end else begin : g_live
      assign rise[i] = in_lines[i] & ~prev_q[i];
    end
  end

endmodule

// File: rtl/evc_group.sv
module evc_group #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] sw_set,
  input  logic [W-1:0] sw_clr,
  input  logic         mask_we,
  input  logic         xmask_we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic [W-1:0] xmask,
  output logic [W-1:0] mflag,
  output logic [W-1:0] xflag,
  output logic         irq,
  output logic         xany
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '1;
      xmask <= '1;
    end else begin
      pend <= (pend & ~sw_clr) | hw_set | sw_set;
      if (mask_we)  mask  <= wd;
      if (xmask_we) xmask <= wd;
    end
  end

  assign mflag = pend & ~mask;
  assign xflag = pend & ~xmask;
  assign irq   = |mflag;
  assign xany  = |xflag;

endmodule

// File: rtl/evc_regif.sv
module evc_regif
  import evc_pkg::*;
#(
  parameter int unsigned NG = 4,
  parameter int unsigned GW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [GW-1:0]        wr_data,
  input  logic [NG*GW-1:0]     pend_all,
  input  logic [NG*GW-1:0]     mask_all,
  input  logic [NG*GW-1:0]     mflag_all,
  input  logic [NG*GW-1:0]     xmask_all,
  input  logic [NG*GW-1:0]     xflag_all,
  output logic [NG*GW-1:0]     set_all,
  output logic [NG*GW-1:0]     clr_all,
  output logic [NG-1:0]        mask_we,
  output logic [NG-1:0]        xmask_we,
  output logic [GW-1:0]        rd_data,
  output logic                 rd_valid
);

  localparam int unsigned NEV = NG * GW;
  localparam int unsigned EVW = $clog2(NEV);

  logic [3:0]        reg_sel;
  logic [WSEL_W-1:0] word_sel;
  logic [GW-1:0]     rd_next;

  assign reg_sel  = region_of(addr);
  assign word_sel = word_of(addr);

  always_comb begin
    set_all  = '0;
    clr_all  = '0;
    mask_we  = '0;
    xmask_we = '0;
    if (wr_en) begin
      for (int g = 0; g < NG; g++) begin
        if (word_sel == WSEL_W'(g)) begin
          case (reg_sel)
            RG_SET:   set_all[g*GW +: GW] = wr_data;
            RG_CLR:   clr_all[g*GW +: GW] = wr_data;
            RG_MASK:  mask_we[g]  = 1'b1;
            RG_XMASK: xmask_we[g] = 1'b1;
            default: ;
          endcase
        end
      end
      if (reg_sel == RG_RAISE && word_sel == '0)
        set_all[wr_data[EVW-1:0]] = 1'b1;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NG; g++) begin
      if (word_sel == WSEL_W'(g)) begin
        case (reg_sel)
          RG_PEND:  rd_next = pend_all[g*GW +: GW];
          RG_MASK:  rd_next = mask_all[g*GW +: GW];
          RG_MFLAG: rd_next = mflag_all[g*GW +: GW];
          RG_XMASK: rd_next = xmask_all[g*GW +: GW];
          RG_XFLAG: rd_next = xflag_all[g*GW +: GW];
          default:  rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/evt_combiner.sv
module evt_combiner
  import evc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned GROUP_W    = 32,
  parameter int unsigned NUM_RSV    = 4,
  localparam int unsigned NEV       = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NEV-1:0]        evt_in,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [GROUP_W-1:0]    wr_data,
  output logic [GROUP_W-1:0]    rd_data,
  output logic                  rd_valid,
  output logic [NUM_GROUPS-1:0] grp_irq,
  output logic                  exc_irq
);

  logic [NEV-1:0]        hw_rise;
  logic [NEV-1:0]        set_all;
  logic [NEV-1:0]        clr_all;
  logic [NEV-1:0]        pend_all;
  logic [NEV-1:0]        mask_all;
  logic [NEV-1:0]        mflag_all;
  logic [NEV-1:0]        xmask_all;
  logic [NEV-1:0]        xflag_all;
  logic [NUM_GROUPS-1:0] mask_we;
  logic [NUM_GROUPS-1:0] xmask_we;
  logic [NUM_GROUPS-1:0] xany;

  evc_edge #(.N(NEV), .NRSV(NUM_RSV)) i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_lines (evt_in),
    .rise     (hw_rise)
  );

  evc_regif #(.NG(NUM_GROUPS), .GW(GROUP_W)) i_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .pend_all  (pend_all),
    .mask_all  (mask_all),
    .mflag_all (mflag_all),
    .xmask_all (xmask_all),
    .xflag_all (xflag_all),
    .set_all   (set_all),
    .clr_all   (clr_all),
    .mask_we   (mask_we),
    .xmask_we  (xmask_we),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    evc_group #(.W(GROUP_W)) i_group (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (hw_rise[g*GROUP_W +: GROUP_W]),
      .sw_set   (set_all[g*GROUP_W +: GROUP_W]),
      .sw_clr   (clr_all[g*GROUP_W +: GROUP_W]),
      .mask_we  (mask_we[g]),
      .xmask_we (xmask_we[g]),
      .wd       (wr_data),
      .pend     (pend_all[g*GROUP_W +: GROUP_W]),
      .mask     (mask_all[g*GROUP_W +: GROUP_W]),
      .xmask    (xmask_all[g*GROUP_W +: GROUP_W]),
      .mflag    (mflag_all[g*GROUP_W +: GROUP_W]),
      .xflag    (xflag_all[g*GROUP_W +: GROUP_W]),
      .irq      (grp_irq[g]),
      .xany     (xany[g])
    );
  end

  assign exc_irq = |xany;

endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int unsigned NG  = 4,
  parameter int unsigned NEV = 128
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NEV-1:0] hw_rise,
  input logic [NEV-1:0] clr_all,
  input logic [NEV-1:0] pend_all,
  input logic [NEV-1:0] mask_all,
  input logic           rd_en,
  input logic           rd_valid,
  input logic [NG-1:0]  grp_irq,
  input logic           exc_irq
);

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rise != '0) |=> ((pend_all & $past(hw_rise)) == $past(hw_rise))); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all != '0) |=> ((pend_all & $past(pend_all & ~clr_all)) == $past(pend_all & ~clr_all))); // R5

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_all) |-> (grp_irq == '0)); // R7

  AST_EXC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    exc_irq |-> (pend_all != '0)); // R8

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en)); // R9

endmodule

bind evt_combiner evc_checker #(.NG(NUM_GROUPS), .NEV(NEV)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hw_rise  (hw_rise),
  .clr_all  (clr_all),
  .pend_all (pend_all),
  .mask_all (mask_all),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .grp_irq  (grp_irq),
  .exc_irq  (exc_irq)
);

// File: tb/test_evt_combiner.sv
`timescale 1ns/1ps
module test_evt_combiner;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt_in = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [8:0]   addr = '0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  rd_data;
  logic         rd_valid;
  logic [3:0]   grp_irq;
  logic         exc_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_pend [4];
  logic [31:0] m_mask [4];
  logic [31:0] m_xmask[4];

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  evt_combiner i_evt_combiner (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .grp_irq(grp_irq), .exc_irq(exc_irq)
  );

  function automatic logic [8:0] ra(input int base, input int word);
    return 9'(base + 4 * word);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 9'h100 && a < 9'h110) m_pend[a[3:2]] |= d;
    if (a >= 9'h120 && a < 9'h130) m_pend[a[3:2]] &= ~d;
    if (a == 9'h140) m_pend[d[6:5]] |= 32'h1 << d[4:0];
    if (a >= 9'h040 && a < 9'h050) m_mask[a[3:2]] = d;
    if (a >= 9'h080 && a < 9'h090) m_xmask[a[3:2]] = d;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int e);
    @(negedge clk);
    evt_in[e] = 1'b1;
    @(negedge clk);
    evt_in[e] = 1'b0;
    if (e >= 4) m_pend[e / 32] |= 32'h1 << (e % 32);
  endtask

  function automatic logic [31:0] irq_exp();
    logic [31:0] r = '0;
    for (int g = 0; g < 4; g++) r[g] = |(m_pend[g] & ~m_mask[g]);
    return r;
  endfunction

  function automatic logic exc_exp();
    logic r = 1'b0;
    for (int g = 0; g < 4; g++) r |= |(m_pend[g] & ~m_xmask[g]);
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected rd_valid, actual %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 4; g++) begin
      m_pend[g] = '0; m_mask[g] = '1; m_xmask[g] = '1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 grp_irq", {28'h0, grp_irq}, 32'h0);
    check("R1 exc_irq", {31'h0, exc_irq}, 32'h0);
    for (int g = 0; g < 4; g++) begin
      rd(ra(9'h000, g), 32'h0, "R1 pending");
      rd(ra(9'h040, g), 32'hFFFF_FFFF, "R1 mask");
      rd(ra(9'h080, g), 32'hFFFF_FFFF, "R1 exception mask");
    end

    // R2: edge latches, flag stays after drop
    pulse(37);
    rd(ra(9'h000, 1), m_pend[1], "R2 latched edge");
    check("R7 masked irq", {28'h0, grp_irq}, irq_exp());

    // R3: reserved inputs ignored
    pulse(0); pulse(2); pulse(3);
    rd(ra(9'h000, 0), 32'h0, "R3 reserved inputs");

    // R7: unmask, masked view
    wr(ra(9'h040, 1), ~32'h20);
    check("R7 grp_irq unmasked", {28'h0, grp_irq}, irq_exp());
    rd(ra(9'h060, 1), 32'h20, "R7 masked view");
    rd(ra(9'h040, 1), ~32'h20, "R7 mask readback");

    // R5: clear with zero data, then clear the bit
    wr(ra(9'h120, 1), 32'h0);
    rd(ra(9'h000, 1), 32'h20, "R5 zero clear no effect");
    wr(ra(9'h120, 1), 32'h20);
    check("R5 grp_irq after clear", {28'h0, grp_irq}, 32'h0);
    rd(ra(9'h000, 1), 32'h0, "R5 cleared");

    // R2: held input does not re-set after clear
    @(negedge clk); evt_in[40] = 1'b1;
    @(negedge clk); m_pend[1] |= 32'h100;
    rd(ra(9'h000, 1), 32'h100, "R2 held input set");
    wr(ra(9'h120, 1), 32'h100);
    repeat (2) @(negedge clk);
    rd(ra(9'h000, 1), 32'h0, "R2 held input no re-set");
    evt_in[40] = 1'b0;

    // R4: set register
    wr(ra(9'h100, 2), 32'hA500_0000);
    wr(ra(9'h100, 2), 32'h0);
    rd(ra(9'h000, 2), 32'hA500_0000, "R4 set word");

    // R6: raise by event number
    wr(9'h140, 32'd100);
    wr(9'h140, 32'd127);
    rd(ra(9'h000, 3), 32'h8000_0010, "R6 raise");

    // R5: edge on event 70 in the same cycle as its clear
    @(negedge clk);
    evt_in[70] = 1'b1;
    wr_en = 1'b1; addr = ra(9'h120, 2); wr_data = 32'h0100_0040;
    @(negedge clk);
    wr_en = 1'b0; evt_in[70] = 1'b0;
    m_pend[2] = (m_pend[2] & ~32'h0100_0040) | 32'h40;
    rd(ra(9'h000, 2), 32'hA400_0040, "R5 set wins over clear");

    // R8: exception path independent of group mask
    check("R8 exc idle", {31'h0, exc_irq}, 32'h0);
    wr(ra(9'h080, 3), ~32'h10);
    check("R8 exc asserted", {31'h0, exc_irq}, {31'h0, exc_exp()});
    check("R8 group3 still masked", {28'h0, grp_irq}, irq_exp());
    rd(ra(9'h0A0, 3), 32'h10, "R8 exception view");
    wr(ra(9'h120, 3), 32'h10);
    check("R8 exc after clear", {31'h0, exc_irq}, {31'h0, exc_exp()});

    // R9: unused and write-only words read zero
    rd(ra(9'h000, 5), 32'h0, "R9 unused word");
    rd(ra(9'h100, 2), 32'h0, "R9 set region reads zero");
    rd(9'h140, 32'h0, "R9 raise reads zero");
    @(negedge clk);
    check("R9 rd_valid idle", {31'h0, rd_valid}, 32'h0);
    check("R9 queue drained", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule